// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator with Two-Level Frequency and Phase Keying

The block is a phase-accumulating oscillator that emits a sine word and a cosine word on every clock. A 48-bit accumulator adds a frequency tuning word on each edge. Two tuning words are stored, and a single select input picks which one is added, so binary frequency keying needs no register traffic. Two 14-bit phase offsets are stored the same way, and a second select input picks one of them for binary phase keying. The selected offset is added to the top 16 accumulator bits. The resulting phase addresses a quarter-wave amplitude table, which gives two signed 12-bit samples 90 degrees apart.

Software loads the four words one byte at a time through a parallel write port into a shadow bank. A one-cycle update pulse then copies the whole shadow bank into the active bank in one step, so the oscillator never runs from a half-loaded word. Phase keying with more than two levels is done by rewriting an offset and pulsing update.

Top module: `quad_nco`

## Requirements
- R1: On every clock edge outside reset, the accumulator advances by the selected active tuning word, modulo 2^48.
- R2: `fskSel` = 0 selects active tuning word 0 and `fskSel` = 1 selects active tuning word 1. The value sampled at an edge sets that edge's increment.
- R3: `pskSel` = 0 selects active offset 0 and `pskSel` = 1 selects active offset 1. The 14-bit offset is placed in bits 15:2 of a 16-bit value, with zeros in bits 1:0, and is added to accumulator bits 47:32 modulo 2^16 to form the phase.
- R4: The phase bits 15:8 form an index k. The sine amplitude is round(2047*sin(2*pi*(k+0.5)/256)), rounded half away from zero, within one LSB. It is given in two's complement and never equals -2048.
- R5: The cosine output equals the R4 amplitude evaluated at phase + 0x4000 (modulo 2^16).
- R6: The outputs are registered. The sample presented after an edge is computed from the accumulator, the active offsets and `pskSel` as they stood just before that edge.
- R7: Byte addresses map to shadow bytes, least significant byte at the lowest address:
  - 0 to 5: tuning word 0
  - 6 to 11: tuning word 1
  - 12 and 13: offset 0
  - 14 and 15: offset 1

  Bits 7:6 of bytes 13 and 15 are dropped.
- R8: Shadow writes have no effect on the outputs until `update` is high at an edge. That edge copies the shadow values held before the edge. A byte written in the same cycle stays in the shadow bank only.
- R9: While `rst` is high at an edge, the accumulator, both banks and both outputs clear to zero.
- R10: Rewriting an active offset through the write port and `update` shifts the output phase by the new offset with no change to `pskSel`. This allows four or more phase levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Shadow byte write enable |
| wrAddr | input | 4 | Shadow byte address |
| wrData | input | 8 | Shadow byte data |
| update | input | 1 | Copy shadow bank to active bank |
| fskSel | input | 1 | Tuning word select |
| pskSel | input | 1 | Phase offset select |
| sinOut | output | 12 | Signed sine sample |
| cosOut | output | 12 | Signed cosine sample |

## Verification
The accumulator and active bank are visible only through the samples. A wrong accumulator step or a wrong tuning-word select shows up as a phase drift. That drift reaches the sample index once the error has built up in bits 47:40. The bench therefore runs each pattern for many cycles with steps large enough to move the index on every edge. A wrong offset, a wrong quadrant fold or a wrong cosine shift shows in the very next sample. A copy to the active bank at the wrong time shows as a step change one cycle off from the reference model, which is compared sample by sample.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W   = 48;
  localparam int PHASE_W = 16;
  localparam int POW_W   = 14;
  localparam int AMP_W   = 12;
  localparam int QADDR_W = 6;

  typedef struct packed {
    logic commit;
    logic fsk;
    logic psk;
  } nco_strobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int ACC_W  = nco_pkg::ACC_W,
  parameter int POW_W  = nco_pkg::POW_W,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [7:0]                 wrData,
  input  logic                       update,
  input  logic                       fskSel,
  input  logic                       pskSel,
  output nco_strobe_t                strobes,
  output logic [1:0][ACC_W-1:0]      shadowFtw,
  output logic [1:0][POW_W-1:0]      shadowPow
);
  localparam int FTW_BYTES = ACC_W / 8;
  localparam int POW_BYTES = (POW_W + 7) / 8;
  localparam int BANK_BYTES = FTW_BYTES + POW_BYTES;
  localparam int NUM_BYTES = 2 * BANK_BYTES;
  localparam int POW_BASE = 2 * FTW_BYTES;

  logic [7:0] shadowByte [NUM_BYTES];
  logic [1:0][POW_BYTES*8-1:0] powWide;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BYTES; b++) shadowByte[b] <= '0;
    end else if (wrEn && (int'(wrAddr) < NUM_BYTES)) begin
      shadowByte[wrAddr] <= wrData;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_word
    for (genvar k = 0; k < FTW_BYTES; k++) begin : g_ftw
      assign shadowFtw[w][8*k +: 8] = shadowByte[w*FTW_BYTES + k];
    end
    for (genvar k = 0; k < POW_BYTES; k++) begin : g_pow
      assign powWide[w][8*k +: 8] = shadowByte[POW_BASE + w*POW_BYTES + k];
    end
    assign shadowPow[w] = powWide[w][POW_W-1:0];
  end

  assign strobes.commit = update;
  assign strobes.fsk    = fskSel;
  assign strobes.psk    = pskSel;

  p_shadow_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(POW_BASE)) |=> shadowPow[0][7:0] == $past(wrData));
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W   = nco_pkg::ACC_W,
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int POW_W   = nco_pkg::POW_W,
  parameter int AMP_W   = nco_pkg::AMP_W,
  parameter int QADDR_W = nco_pkg::QADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  nco_strobe_t               strobes,
  input  logic [1:0][ACC_W-1:0]     shadowFtw,
  input  logic [1:0][POW_W-1:0]     shadowPow,
  output logic signed [AMP_W-1:0]   sinOut,
  output logic signed [AMP_W-1:0]   cosOut
);
  localparam int MAG_W  = AMP_W - 1;
  localparam int QTAB_N = 1 << QADDR_W;
  localparam real MAG_MAX = real'((1 << MAG_W) - 1);
  localparam real HALF_PI = 1.5707963267948966;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

  function automatic int sinMag(input int idx);
    real x, term, s;
    x = (real'(idx) + 0.5) * HALF_PI / real'(QTAB_N);
    term = x;
    s = x;
    for (int n = 1; n < 10; n++) begin
      term = -term * x * x / real'((2*n) * (2*n + 1));
      s = s + term;
    end
    return $rtoi(MAG_MAX * s + 0.5);
  endfunction

  logic [ACC_W-1:0]          acc;
  logic [1:0][ACC_W-1:0]     actFtw;
  logic [1:0][POW_W-1:0]     actPow;
  logic [PHASE_W-1:0]        phaseSum;
  logic [MAG_W-1:0]          qTab [QTAB_N];
  logic signed [AMP_W-1:0]   ampQ [2];

  for (genvar g = 0; g < QTAB_N; g++) begin : g_tab
    assign qTab[g] = MAG_W'(sinMag(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      actFtw <= '0;
      actPow <= '0;
    end else begin
      acc <= acc + actFtw[strobes.fsk];
      if (strobes.commit) begin
        actFtw <= shadowFtw;
        actPow <= shadowPow;
      end
    end
  end

  assign phaseSum = acc[ACC_W-1 -: PHASE_W]
                  + {actPow[strobes.psk], {(PHASE_W-POW_W){1'b0}}};

  for (genvar i = 0; i < 2; i++) begin : g_chan
    localparam logic [PHASE_W-1:0] OFFS = (i == 1) ? QUARTER : '0;
    logic [PHASE_W-1:0]      chPh;
    logic [1:0]              quad;
    logic [QADDR_W-1:0]      addr;
    logic signed [AMP_W-1:0] posVal;

    always_comb begin
      chPh   = phaseSum + OFFS;
      quad   = chPh[PHASE_W-1 -: 2];
      addr   = chPh[PHASE_W-3 -: QADDR_W];
      posVal = {1'b0, qTab[quad[0] ? ~addr : addr]};
    end

    always_ff @(posedge clk) begin
      if (rst) ampQ[i] <= '0;
      else     ampQ[i] <= quad[1] ? -posVal : posVal;
    end
  end

  assign sinOut = ampQ[0];
  assign cosOut = ampQ[1];

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (acc == '0 && ampQ[0] == '0 && ampQ[1] == '0));
  p_commit_load_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |=> (actFtw == $past(shadowFtw) && actPow == $past(shadowPow)));
  p_hold_active_r8: assert property (@(posedge clk) disable iff (rst)
    !strobes.commit |=> ($stable(actFtw) && $stable(actPow)));
  p_zero_step_r1: assert property (@(posedge clk) disable iff (rst)
    (actFtw[strobes.fsk] == '0) |=> $stable(acc));
  p_amp_range_r4: assert property (@(posedge clk) disable iff (rst)
    (sinOut != {1'b1, {(AMP_W-1){1'b0}}} && cosOut != {1'b1, {(AMP_W-1){1'b0}}}));
endmodule

// File: rtl/quad_nco.sv
module quad_nco
  import nco_pkg::*;
#(
  parameter int ACC_W   = nco_pkg::ACC_W,
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int POW_W   = nco_pkg::POW_W,
  parameter int AMP_W   = nco_pkg::AMP_W,
  parameter int QADDR_W = nco_pkg::QADDR_W,
  localparam int ADDR_W = $clog2(2 * (ACC_W/8 + (POW_W+7)/8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              update,
  input  logic              fskSel,
  input  logic              pskSel,
  output logic [AMP_W-1:0]  sinOut,
  output logic [AMP_W-1:0]  cosOut
);
  nco_strobe_t           strobes;
  logic [1:0][ACC_W-1:0] shadowFtw;
  logic [1:0][POW_W-1:0] shadowPow;
  logic signed [AMP_W-1:0] sinS, cosS;

  nco_ctrl #(.ACC_W(ACC_W), .POW_W(POW_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .update(update), .fskSel(fskSel), .pskSel(pskSel),
    .strobes(strobes), .shadowFtw(shadowFtw), .shadowPow(shadowPow)
  );

  nco_datapath #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .POW_W(POW_W),
                 .AMP_W(AMP_W), .QADDR_W(QADDR_W)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .shadowFtw(shadowFtw), .shadowPow(shadowPow),
    .sinOut(sinS), .cosOut(cosS)
  );

  assign sinOut = sinS;
  assign cosOut = cosS;
endmodule

// File: tb/test_quad_nco.sv
`timescale 1ns/1ps
module test_quad_nco;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic update = 1'b0;
  logic fskSel = 1'b0;
  logic pskSel = 1'b0;
  logic [11:0] sinOut, cosOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_nco i_quad_nco (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .update(update), .fskSel(fskSel), .pskSel(pskSel),
    .sinOut(sinOut), .cosOut(cosOut)
  );

  // Expected amplitude from the requirement formula (R4)
  function automatic int expAmp(input logic [15:0] ph);
    real v;
    v = 2047.0 * $sin(2.0 * PI * (real'(ph[15:8]) + 0.5) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // Specification-level reference model
  logic [7:0]  sB [16];
  logic [47:0] mF [2];
  logic [13:0] mP [2];
  logic [47:0] mAcc;
  int mSin = 0, mCos = 0;

  always @(posedge clk) begin
    logic [15:0] ph;
    if (rst) begin
      for (int b = 0; b < 16; b++) sB[b] = '0;
      mF[0] = '0; mF[1] = '0; mP[0] = '0; mP[1] = '0;
      mAcc = '0; mSin = 0; mCos = 0;
    end else begin
      ph = mAcc[47:32] + {mP[pskSel], 2'b00};
      mSin = expAmp(ph);
      mCos = expAmp(ph + 16'h4000);
      mAcc = mAcc + mF[fskSel];
      if (update) begin
        for (int w = 0; w < 2; w++) begin
          mF[w] = {sB[w*6+5], sB[w*6+4], sB[w*6+3], sB[w*6+2], sB[w*6+1], sB[w*6]};
          mP[w] = {sB[12+w*2+1][5:0], sB[12+w*2]};
        end
      end
      if (wrEn) sB[wrAddr] = wrData;
    end
  end

  task automatic check(input string req);
    int s, c, ds, dc;
    s = int'($signed(sinOut));
    c = int'($signed(cosOut));
    ds = s - mSin; dc = c - mCos;
    nChecks++;
    if (ds > 1 || ds < -1 || dc > 1 || dc < -1) begin
      nFails++;
      $display("FAIL %s: sin=%0d cos=%0d expected sin=%0d cos=%0d", req, s, c, mSin, mCos);
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    check(req);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic wrByte(input int a, input logic [7:0] d, input string req);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    step(req);
    wrEn = 1'b0;
  endtask

  task automatic wrFtw(input int sel, input logic [47:0] v, input string req);
    for (int k = 0; k < 6; k++) wrByte(sel*6 + k, v[8*k +: 8], req);
  endtask

  task automatic wrPow(input int sel, input logic [13:0] v, input string req);
    wrByte(12 + sel*2, v[7:0], req);
    wrByte(13 + sel*2, {2'b11, v[13:8]}, req); // top bits must be dropped (R7)
  endtask

  task automatic pulseUpdate(input string req);
    update = 1'b1;
    step(req);
    update = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    nChecks++;
    if (sinOut !== 12'd0 || cosOut !== 12'd0) begin
      nFails++;
      $display("FAIL R9: sin=%0h cos=%0h expected 0 0", sinOut, cosOut);
    end
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    doReset();
    run(4, "R9 R4 R5 idle after reset");
  endtask

  task automatic t_write_no_update();
    wrFtw(0, 48'h0100_0000_0000, "R8 partial tuning write invisible");
    run(3, "R8 no update");
  endtask

  task automatic t_commit_and_run();
    pulseUpdate("R8 commit");
    run(40, "R1 R6 tuning word 0 running");
  endtask

  task automatic t_fsk();
    wrFtw(1, 48'h0730_0000_1234, "R7 tuning word 1 bytes");
    pulseUpdate("R8 commit word 1");
    fskSel = 1'b1; run(20, "R2 fsk select 1");
    fskSel = 1'b0; run(10, "R2 fsk select 0");
    fskSel = 1'b1; step("R2 fsk toggle"); fskSel = 1'b0; run(5, "R2 fsk toggle");
  endtask

  task automatic t_psk();
    wrPow(1, 14'h2000, "R7 offset 1");
    wrPow(0, 14'h3FFF, "R7 offset 0");
    pulseUpdate("R8 commit offsets");
    pskSel = 1'b1; run(10, "R3 half-turn offset");
    pskSel = 1'b0; run(10, "R3 offset wrap");
  endtask

  task automatic t_wrap_acc();
    doReset();
    wrFtw(0, 48'hFFFF_FFFF_FFFF, "R1 negative step");
    wrFtw(1, 48'h4000_0000_0000, "R1 quarter step");
    pulseUpdate("R1 commit");
    run(8, "R1 accumulator wrap down");
    fskSel = 1'b1; run(8, "R1 quarter turn per cycle"); fskSel = 1'b0;
  endtask

  task automatic t_same_cycle();
    wrEn = 1'b1; wrAddr = 4'd5; wrData = 8'h22; update = 1'b1;
    step("R8 write with update");
    wrEn = 1'b0; update = 1'b0;
    run(6, "R8 same-cycle byte held in shadow");
    pulseUpdate("R8 later commit");
    run(6, "R8 byte now active");
  endtask

  task automatic t_multi_psk();
    logic [13:0] lv [4];
    doReset();
    lv[0] = 14'h0000; lv[1] = 14'h1000; lv[2] = 14'h2000; lv[3] = 14'h3000;
    wrFtw(0, 48'h0003_0000_0000, "R10 slow carrier");
    for (int s = 0; s < 4; s++) begin
      wrPow(0, lv[s], "R10 rewrite offset");
      pulseUpdate("R10 commit level");
      run(3, "R10 four-level phase");
    end
  endtask

  task automatic t_reset_mid();
    fskSel = 1'b1;
    doReset();
    run(4, "R9 cleared state stays idle");
    fskSel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_write_no_update();
    t_commit_and_run();
    t_fsk();
    t_psk();
    t_wrap_acc();
    t_same_cycle();
    t_multi_psk();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule